// File: doc/BRIEF.md
# Shared Undervoltage Event Accumulator

This block turns the undervoltage comparator outputs of a dual-channel regulator controller into one protective decision. Once per switching cycle a strobe marks the moment to sample both comparator outputs. The comparators already apply their own hysteresis. Every sampled fault adds to a single 4-bit count, so two channels that fault in the same cycle add two. When the count would pass its top value, the block latches a request to shut down both channels.

The count never restarts because one channel recovers. Only an explicit clear or a reset brings the block back to its idle state. An enable input lets the controller hold off accumulation, for example during start-up. The count value and the per-channel flags seen at the last accepted strobe are exposed for debug.

Top module: `uv_fault_accum`

## Requirements
- R1: After reset, `fault_count` is 0, `shutdown_req` is 0 and `chan_fault` is all zeros.
- R2: A strobe is accepted when `cyc_strobe`=1, `enable`=1 and `clear`=0. On an accepted strobe with no shutdown pending and exactly one bit of `uv_flag` set, `fault_count` rises by one on the next clock edge, provided the sum stays at or below 15.
- R3: On an accepted strobe with both `uv_flag` bits set and no shutdown pending, `fault_count` rises by two, provided the sum stays at or below 15.
- R4: If an accepted strobe would take the count above 15, `fault_count` becomes 15 (it saturates and does not wrap) and `shutdown_req` goes to 1 on the same edge. This happens for 15 plus one, and for 14 or 15 plus two. Reaching exactly 15 (14 plus one) does not raise `shutdown_req`.
- R5: Once set, `shutdown_req` stays 1 until a clear or a reset. While it is 1, accepted strobes do not change `fault_count`.
- R6: Without an accepted strobe (`cyc_strobe`=0 or `enable`=0), `fault_count` and `chan_fault` keep their values.
- R7: `clear`=1 sets `fault_count`, `shutdown_req` and `chan_fault` to zero on the next edge. It takes priority over a strobe in the same cycle.
- R8: An accepted strobe with no `uv_flag` bit set leaves `fault_count` unchanged. A channel that recovers never resets the count.
- R9: After each accepted strobe, `chan_fault[i]` equals the `uv_flag[i]` value sampled at that strobe, for channel i (bit 0 is channel 0, bit 1 is channel 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| enable | input | 1 | Allows strobes to be accepted |
| clear | input | 1 | Zeroes the count, the shutdown request and the flags |
| cyc_strobe | input | 1 | One pulse per switching cycle; marks the sampling point |
| uv_flag | input | 2 | Undervoltage comparator outputs, with hysteresis already applied, one bit per channel |
| shutdown_req | output | 1 | Latched request to shut down both channels |
| fault_count | output | 4 | Current value of the shared event count (debug) |
| chan_fault | output | 2 | Per-channel flags as sampled at the last accepted strobe |

## Verification
If the count state is wrong, the error shows on `fault_count` one edge after the strobe that caused it. A wrong increment, a wrapped count or a missed hold is therefore caught on the very cycle it happens. A broken overflow decision shows on `shutdown_req` at that same edge. A latch that fails to hold shows as a drop in `shutdown_req` on a cycle with no clear. The bench keeps its own expected count and compares it with the outputs after every cycle, so any divergence is reported within one clock.

// File: rtl/uvacc_pkg.sv
package uvacc_pkg;
  // Per-cycle control decoded at the block edge
  typedef struct packed {
    logic accept;  // strobe taken this cycle
    logic wipe;    // clear request, wins over accept
  } uvacc_ctl_t;
endpackage

// File: rtl/uvacc_rst_sync.sv
module uvacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uvacc_event_sum.sv
module uvacc_event_sum #(
  parameter int NCH   = 2,
  parameter int SUM_W = $clog2(NCH + 1)
) (
  input  logic [NCH-1:0]   flags,
  output logic [SUM_W-1:0] total
);
  logic [SUM_W-1:0] partial [NCH+1];

  assign partial[0] = '0;
  for (genvar g = 0; g < NCH; g++) begin : g_add
    assign partial[g+1] = partial[g] + {{(SUM_W-1){1'b0}}, flags[g]};
  end

  assign total = partial[NCH];
endmodule

// File: rtl/uvacc_sat_counter.sv
module uvacc_sat_counter #(
  parameter int CNT_W = 4,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             step_en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int EXT_W = CNT_W + INC_W;
  localparam logic [EXT_W-1:0] TOP = EXT_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] sum_ext;

  always_comb begin
    sum_ext = {{INC_W{1'b0}}, cnt_q} + {{CNT_W{1'b0}}, inc};
    ovf     = 1'b0;
    cnt_d   = cnt_q;
    if (wipe) begin
      cnt_d = '0;
    end else if (step_en) begin
      if (sum_ext > TOP) begin
        ovf   = 1'b1;
        cnt_d = TOP[CNT_W-1:0];
      end else begin
        cnt_d = sum_ext[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/uv_fault_accum.sv
module uv_fault_accum #(
  parameter int NCH   = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             cyc_strobe,
  input  logic [NCH-1:0]   uv_flag,
  output logic             shutdown_req,
  output logic [CNT_W-1:0] fault_count,
  output logic [NCH-1:0]   chan_fault
);
  import uvacc_pkg::*;

  localparam int SUM_W = $clog2(NCH + 1);

  logic             rst_q_n;
  uvacc_ctl_t       ctl;
  logic [SUM_W-1:0] ev_total;
  logic             ovf_hit;
  logic             sd_q, sd_d;
  logic [NCH-1:0]   flag_q, flag_d;

  uvacc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  always_comb begin
    ctl.wipe   = clear;
    ctl.accept = cyc_strobe && enable && !clear;
  end

  uvacc_event_sum #(.NCH(NCH), .SUM_W(SUM_W)) u_sum (
    .flags (uv_flag),
    .total (ev_total)
  );

  uvacc_sat_counter #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wipe    (ctl.wipe),
    .step_en (ctl.accept && !sd_q),
    .inc     (ev_total),
    .count   (fault_count),
    .ovf     (ovf_hit)
  );

  always_comb begin
    sd_d   = sd_q;
    flag_d = flag_q;
    if (ctl.wipe) begin
      sd_d   = 1'b0;
      flag_d = '0;
    end else if (ctl.accept) begin
      flag_d = uv_flag;
      if (ovf_hit) sd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sd_q   <= 1'b0;
      flag_q <= '0;
    end else begin
      sd_q   <= sd_d;
      flag_q <= flag_d;
    end
  end

  assign shutdown_req = sd_q;
  assign chan_fault   = flag_q;
endmodule

// File: rtl/uv_fault_accum_chk.sv
module uv_fault_accum_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             clear,
  input logic             cyc_strobe,
  input logic [NCH-1:0]   uv_flag,
  input logic             shutdown_req,
  input logic [CNT_W-1:0] fault_count,
  input logic [NCH-1:0]   chan_fault
);
  localparam int MAXC = (1 << CNT_W) - 1;

  logic acc;
  assign acc = cyc_strobe && enable && !clear;

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !shutdown_req && $countones(uv_flag) == 1 && int'(fault_count) < MAXC)
      |=> (int'(fault_count) == int'($past(fault_count)) + 1));

  a_r3_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !shutdown_req && $countones(uv_flag) == 2 && int'(fault_count) <= MAXC - 2)
      |=> (int'(fault_count) == int'($past(fault_count)) + 2));

  a_r4_saturate_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !shutdown_req && int'(fault_count) + $countones(uv_flag) > MAXC)
      |=> (shutdown_req && int'(fault_count) == MAXC));

  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req && !clear) |=> (shutdown_req && $stable(fault_count)));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !clear) |=> ($stable(fault_count) && $stable(chan_fault)));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fault_count == '0 && !shutdown_req && chan_fault == '0));

  a_r8_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && uv_flag == '0) |=> $stable(fault_count));

  a_r9_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (chan_fault == $past(uv_flag)));
endmodule

bind uv_fault_accum uv_fault_accum_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .enable       (enable),
  .clear        (clear),
  .cyc_strobe   (cyc_strobe),
  .uv_flag      (uv_flag),
  .shutdown_req (shutdown_req),
  .fault_count  (fault_count),
  .chan_fault   (chan_fault)
);

// File: tb/sim_uv_fault_accum.sv
`timescale 1ns/1ps
module sim_uv_fault_accum;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       clear = 1'b0;
  logic       cyc_strobe = 1'b0;
  logic [1:0] uv_flag = 2'b00;
  logic       shutdown_req;
  logic [3:0] fault_count;
  logic [1:0] chan_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         m_cnt;
  bit         m_sd;
  logic [1:0] m_flag;

  always #2.5 clk = ~clk;

  uv_fault_accum u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .cyc_strobe(cyc_strobe), .uv_flag(uv_flag),
    .shutdown_req(shutdown_req), .fault_count(fault_count), .chan_fault(chan_fault)
  );

  function automatic int next_cnt(int c, bit sd, logic [1:0] f);
    int s;
    if (sd) return c;
    s = c + int'(f[0]) + int'(f[1]);
    return (s > 15) ? 15 : s;
  endfunction

  function automatic bit next_sd(int c, bit sd, logic [1:0] f);
    return sd || (c + int'(f[0]) + int'(f[1]) > 15);
  endfunction

  task automatic check(string req);
    checks++;
    if (int'(fault_count) != m_cnt || shutdown_req != m_sd || chan_fault != m_flag) begin
      errors++;
      $display("FAIL %s: got cnt=%0d sd=%0b flag=%b, expected cnt=%0d sd=%0b flag=%b",
               req, fault_count, shutdown_req, chan_fault, m_cnt, m_sd, m_flag);
    end
  endtask

  task automatic cycle(bit s, logic [1:0] f, bit e, bit c, string req);
    @(negedge clk);
    cyc_strobe = s; uv_flag = f; enable = e; clear = c;
    if (c) begin
      m_cnt = 0; m_sd = 0; m_flag = 2'b00;
    end else if (s && e) begin
      m_flag = f;
      m_sd   = next_sd(m_cnt, m_sd, f);
      m_cnt  = next_cnt(m_cnt, m_sd && !next_sd(m_cnt, 0, f) ? 1'b1 : 1'b0, f);
    end
    @(posedge clk);
    #1;
    cyc_strobe = 0; clear = 0;
    check(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_cnt = 0; m_sd = 0; m_flag = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1");

    // R2 single steps on each channel
    cycle(1, 2'b01, 1, 0, "R2");
    cycle(1, 2'b10, 1, 0, "R2");
    // R3 both channels
    cycle(1, 2'b11, 1, 0, "R3");
    // R8 one recovers, other still faulting, then none
    cycle(1, 2'b01, 1, 0, "R8");
    cycle(1, 2'b00, 1, 0, "R8");
    // R6 no strobe, enable low
    cycle(0, 2'b11, 1, 0, "R6");
    cycle(1, 2'b11, 0, 0, "R6");
    // R9 flag capture
    cycle(1, 2'b10, 1, 0, "R9");
    // climb to 14
    while (m_cnt < 14) cycle(1, (m_cnt <= 12) ? 2'b11 : 2'b01, 1, 0, "R3");
    // R4: 14+1 reaches 15 without shutdown
    cycle(1, 2'b01, 1, 0, "R4");
    // R4: 15+1 trips
    cycle(1, 2'b01, 1, 0, "R4");
    // R5 stays latched, count frozen
    cycle(1, 2'b11, 1, 0, "R5");
    cycle(0, 2'b00, 1, 0, "R5");
    // R7 clear with strobe
    cycle(1, 2'b11, 1, 1, "R7");
    // R4: 14+2 trips
    while (m_cnt < 14) cycle(1, 2'b11, 1, 0, "R3");
    cycle(1, 2'b11, 1, 0, "R4");
    cycle(0, 2'b00, 1, 1, "R7");

    for (int i = 0; i < 400; i++) begin
      bit s, e, c;
      s = ($urandom % 4) != 0;
      e = ($urandom % 8) != 0;
      c = ($urandom % 40) == 0;
      cycle(s, 2'($urandom), e, c, "R2/R3/R4/R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule